// File: doc/BRIEF.md
# Mux-Merger Binary Sorter

This block sorts a vector of one-bit keys into ascending order, with zeros gathered at element 0 and ones at the top index. Each key carries a payload tag, and the tag leaves on whichever output lane its key lands on. The sorter is built recursively. Two half-size sorters leave the vector bisorted, which means both halves are in order. A merge stage then finishes the job without an adder and without comparators, except in its two-element base case.

The merge stage reads the first key of the second quarter and the first key of the fourth quarter. Those two bits form a code. The code tells which two quarters are already constant and which two, placed side by side, form a bisorted half. A quarter swapper on the input side routes that half into a half-size merge stage. A second swapper on the output side puts the constant quarters and the merged half back in order. The size is a parameter and must be a power of two, at least 2. The sorting network is pure logic, and a single register stage at the outputs holds the result.

Top module: `bsort_top`

## Requirements
- R1: One clock edge after a vector is applied, `key_o` is in ascending order. For every i, `key_o[i]` is not greater than `key_o[i+1]`. Element 0 is the lowest lane.
- R2: The number of ones in `key_o` equals the number of ones in the `key_i` vector that was sampled at the previous edge.
- R3: The tags travel with their keys. Output lane j carries tag `tag_o[j*TAG_W +: TAG_W]`, and the (key, tag) pairs on the outputs are a permutation of the pairs that were sampled on the inputs. Input lane i's tag is `tag_i[i*TAG_W +: TAG_W]`.
- R4: The latency is exactly one clock. The outputs keep the previous result until the next rising edge of `clk_i`, and they depend only on the inputs sampled at that edge.
- R5: While `rst_ni` is low, `key_o` and `tag_o` are all zeros. Reset acts without waiting for a clock.
- R6: Correct sorting holds for every key pattern, including all zeros, all ones, and the patterns whose halves split unevenly. This is shown exhaustively for N = 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | N | Unsorted keys, lane i at bit i |
| tag_i | input | N*TAG_W | Payload tags, lane i at bits [i*TAG_W +: TAG_W] |
| key_o | output | N | Sorted keys, registered |
| tag_o | output | N*TAG_W | Tags following their keys, registered |

## Verification
The sorting network is combinational, and only the output register stands between the inputs and the ports. A vector driven on a falling edge must therefore appear just after the next rising edge. The bench drives on the falling edge and samples 5 ns after the following rising edge. To check the one-cycle latency, it also samples the outputs between the drive and that edge and confirms that the old result is still present there. Reset is checked both at start-up and in the middle of a run. The mid-run check samples a few nanoseconds after `rst_ni` falls, with no clock edge in between.

// File: rtl/bsort_pkg.sv
`timescale 1ns/1ps
package bsort_pkg;
  // merge select: {first key of quarter 2, first key of quarter 4}
  typedef enum logic [1:0] {
    MC_LOW      = 2'b00,
    MC_SPLIT_HI = 2'b01,
    MC_SPLIT_LO = 2'b10,
    MC_HIGH     = 2'b11
  } mcode_e;

  function automatic mcode_e mcode_of(input logic q2_head, input logic q4_head);
    return mcode_e'({q2_head, q4_head});
  endfunction
endpackage

// File: rtl/bsort_cmpx.sv
`timescale 1ns/1ps
module bsort_cmpx #(
  parameter int EW = 2
) (
  input  logic [2*EW-1:0] d_i,
  output logic [2*EW-1:0] d_o
);
  logic [EW-1:0] lo, hi;
  logic          swap;

  assign lo   = d_i[0 +: EW];
  assign hi   = d_i[EW +: EW];
  assign swap = lo[0] & ~hi[0];
  assign d_o  = swap ? {lo, hi} : {hi, lo};
endmodule

// File: rtl/bsort_qswap_in.sv
`timescale 1ns/1ps
module bsort_qswap_in
  import bsort_pkg::*;
#(
  parameter int QW = 2
) (
  input  mcode_e          code_i,
  input  logic [4*QW-1:0] d_i,
  output logic [4*QW-1:0] d_o
);
  logic [QW-1:0] q1, q2, q3, q4;

  assign q1 = d_i[0    +: QW];
  assign q2 = d_i[QW   +: QW];
  assign q3 = d_i[2*QW +: QW];
  assign q4 = d_i[3*QW +: QW];

  // slots 0,1 carry the constant quarters, slots 2,3 the bisorted pair
  always_comb begin
    case (code_i)
      MC_LOW:      d_o = {q4, q2, q3, q1};
      MC_SPLIT_HI: d_o = {q3, q2, q4, q1};
      MC_SPLIT_LO: d_o = {q4, q1, q2, q3};
      MC_HIGH:     d_o = {q3, q1, q4, q2};
      default:     d_o = {q4, q2, q3, q1};
    endcase
  end
endmodule

// File: rtl/bsort_qswap_out.sv
`timescale 1ns/1ps
module bsort_qswap_out
  import bsort_pkg::*;
#(
  parameter int QW = 2
) (
  input  mcode_e          code_i,
  input  logic [2*QW-1:0] c_i,
  input  logic [2*QW-1:0] m_i,
  output logic [4*QW-1:0] d_o
);
  logic [QW-1:0] c0, c1;

  assign c0 = c_i[0  +: QW];
  assign c1 = c_i[QW +: QW];

  always_comb begin
    case (code_i)
      MC_LOW:      d_o = {m_i, c1, c0};
      MC_SPLIT_HI,
      MC_SPLIT_LO: d_o = {c1, m_i, c0};
      MC_HIGH:     d_o = {c1, c0, m_i};
      default:     d_o = {m_i, c1, c0};
    endcase
  end
endmodule

// File: rtl/bsort_merge.sv
`timescale 1ns/1ps
module bsort_merge
  import bsort_pkg::*;
#(
  parameter int M  = 4,
  parameter int EW = 2
) (
  input  logic [M*EW-1:0] d_i,
  output logic [M*EW-1:0] d_o
);
  generate
    if (M == 2) begin : g_base
      bsort_cmpx #(.EW(EW)) u_cmpx (.d_i(d_i), .d_o(d_o));
    end else begin : g_rec
      localparam int Q  = M / 4;
      localparam int QW = Q * EW;
      localparam int HW = 2 * QW;

      mcode_e          code;
      logic [4*QW-1:0] staged;
      logic [HW-1:0]   merged;

      assign code = mcode_of(d_i[QW], d_i[3*QW]);

      bsort_qswap_in #(.QW(QW)) u_in (
        .code_i(code),
        .d_i   (d_i),
        .d_o   (staged)
      );

      bsort_merge #(.M(M/2), .EW(EW)) u_sub (
        .d_i(staged[HW +: HW]),
        .d_o(merged)
      );

      bsort_qswap_out #(.QW(QW)) u_out (
        .code_i(code),
        .c_i   (staged[0 +: HW]),
        .m_i   (merged),
        .d_o   (d_o)
      );
    end
  endgenerate
endmodule

// File: rtl/bsort_sort.sv
`timescale 1ns/1ps
module bsort_sort #(
  parameter int M  = 4,
  parameter int EW = 2
) (
  input  logic [M*EW-1:0] d_i,
  output logic [M*EW-1:0] d_o
);
  generate
    if (M == 2) begin : g_base
      bsort_cmpx #(.EW(EW)) u_cmpx (.d_i(d_i), .d_o(d_o));
    end else begin : g_rec
      localparam int HW = (M / 2) * EW;

      logic [M*EW-1:0] bisorted;

      bsort_sort #(.M(M/2), .EW(EW)) u_lo (
        .d_i(d_i[0 +: HW]),
        .d_o(bisorted[0 +: HW])
      );

      bsort_sort #(.M(M/2), .EW(EW)) u_hi (
        .d_i(d_i[HW +: HW]),
        .d_o(bisorted[HW +: HW])
      );

      bsort_merge #(.M(M), .EW(EW)) u_merge (
        .d_i(bisorted),
        .d_o(d_o)
      );
    end
  endgenerate
endmodule

// File: rtl/bsort_top.sv
`timescale 1ns/1ps
module bsort_top #(
  parameter int N     = 16,
  parameter int TAG_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N-1:0]       key_i,
  input  logic [N*TAG_W-1:0] tag_i,
  output logic [N-1:0]       key_o,
  output logic [N*TAG_W-1:0] tag_o
);
  localparam int EW = TAG_W + 1;
  localparam int VW = N * EW;

  logic [VW-1:0]      packed_in, packed_out;
  logic [N-1:0]       key_d;
  logic [N*TAG_W-1:0] tag_d;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign packed_in[i*EW +: EW] = {tag_i[i*TAG_W +: TAG_W], key_i[i]};
    assign key_d[i]                = packed_out[i*EW];
    assign tag_d[i*TAG_W +: TAG_W] = packed_out[i*EW+1 +: TAG_W];
  end

  bsort_sort #(.M(N), .EW(EW)) u_sort (
    .d_i(packed_in),
    .d_o(packed_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_o <= '0;
      tag_o <= '0;
    end else begin
      key_o <= key_d;
      tag_o <= tag_d;
    end
  end

  // checking support: one edge seen out of reset, and element folds
  logic          past_ok;
  logic [EW-1:0] fold_in, fold_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_comb begin
    fold_in  = '0;
    fold_out = '0;
    for (int i = 0; i < N; i++) begin
      fold_in  ^= {tag_i[i*TAG_W +: TAG_W], key_i[i]};
      fold_out ^= {tag_o[i*TAG_W +: TAG_W], key_o[i]};
    end
  end

  AST_OUT_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((key_o << 1) & ~key_o) == '0) else $error("key_o not ascending"); // R1

  AST_ONES_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ($countones(key_o) == $countones($past(key_i))))
    else $error("ones count changed"); // R2

  AST_PAYLOAD_FOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (fold_out == $past(fold_in)))
    else $error("key/tag pairs not conserved"); // R3

  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(past_ok) && ($past(key_i) == $past(key_i, 2))
      && ($past(tag_i) == $past(tag_i, 2)))
    |-> ($stable(key_o) && $stable(tag_o)))
    else $error("output not a function of previous inputs"); // R4
endmodule

// File: tb/sim_bsort_top.sv
`timescale 1ns/1ps
module sim_bsort_top;
  localparam int N     = 8;
  localparam int TW    = 3;
  localparam int WD_NS = 200000 * 20;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    key_i = '0;
  logic [N*TW-1:0] tag_i = '0;
  logic [N-1:0]    key_o;
  logic [N*TW-1:0] tag_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  int  perm [N];

  always #10 clk_i = ~clk_i;

  bsort_top #(.N(N), .TAG_W(TW)) u0 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .key_i (key_i),
    .tag_i (tag_i),
    .key_o (key_o),
    .tag_o (tag_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] sorted_of(input logic [N-1:0] k);
    logic [N-1:0] r = '0;
    int ones = $countones(k);
    for (int i = 0; i < N; i++) r[i] = (i >= N - ones);
    return r;
  endfunction

  // tags are a permutation of 0..N-1: each must appear once with its own key
  task automatic check_result(input logic [N-1:0] k, input logic [N*TW-1:0] t, input string tagname);
    logic [N-1:0] key_by_tag = '0;
    logic [N-1:0] seen = '0;
    bit ok = 1'b1;
    int bad = 0;
    for (int p = 0; p < N; p++) key_by_tag[t[p*TW +: TW]] = k[p];
    check(key_o == sorted_of(k), "R1/R2/R6 sorted keys", 32'(key_o), 32'(sorted_of(k)));
    for (int j = 0; j < N; j++) begin
      int tg = int'(tag_o[j*TW +: TW]);
      if (seen[tg] || key_o[j] != key_by_tag[tg]) begin ok = 1'b0; bad = j; end
      seen[tg] = 1'b1;
    end
    check(ok, tagname, 32'(bad), 32'(N));
  endtask

  task automatic apply(input logic [N-1:0] k, input logic [N*TW-1:0] t);
    @(negedge clk_i);
    key_i = k;
    tag_i = t;
    @(posedge clk_i);
    #5;
  endtask

  function automatic logic [N*TW-1:0] pack_perm();
    logic [N*TW-1:0] r = '0;
    for (int i = 0; i < N; i++) r[i*TW +: TW] = TW'(perm[i]);
    return r;
  endfunction

  task automatic shuffle();
    for (int i = 0; i < N; i++) perm[i] = i;
    for (int i = N - 1; i > 0; i--) begin
      int j = int'($urandom % (i + 1));
      int x = perm[i];
      perm[i] = perm[j];
      perm[j] = x;
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    #(WD_NS);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog expired act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [N*TW-1:0] ident;
    int seed;
    seed = int'($urandom(32'h5EED_0042));
    for (int i = 0; i < N; i++) ident[i*TW +: TW] = TW'(i);

    // R5: reset state with busy inputs
    key_i = '1;
    tag_i = ident;
    repeat (3) @(posedge clk_i);
    #5;
    check(key_o == '0, "R5 reset key", 32'(key_o), 0);
    check(tag_o == '0, "R5 reset tag", 32'(tag_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R6: exhaustive keys at N=8 with identity tags
    for (int v = 0; v < (1 << N); v++) begin
      apply(N'(v), ident);
      check_result(N'(v), ident, "R3 tag permutation");
    end

    // directed corners with shuffled tags
    shuffle();
    apply('0, pack_perm());
    check_result('0, pack_perm(), "R3 all-zero tags");
    shuffle();
    apply('1, pack_perm());
    check_result('1, pack_perm(), "R3 all-one tags");
    shuffle();
    apply(8'b0000_1111, pack_perm());
    check_result(8'b0000_1111, pack_perm(), "R3 reversed halves");

    // random keys, random tag permutations
    for (int n = 0; n < 300; n++) begin
      logic [N-1:0] k = N'($urandom);
      shuffle();
      apply(k, pack_perm());
      check_result(k, pack_perm(), "R3 random tags");
    end

    // R4: old result holds until the edge, new one right after it
    apply('0, ident);
    @(negedge clk_i);
    key_i = '1;
    #2;
    check(key_o == '0, "R4 held before edge", 32'(key_o), 0);
    @(posedge clk_i);
    #5;
    check(key_o == '1, "R4 updated after edge", 32'(key_o), 32'(8'hFF));

    // R5: asynchronous reset mid-run
    @(negedge clk_i);
    #3;
    rst_ni = 1'b0;
    #2;
    check(key_o == '0 && tag_o == '0, "R5 async reset", 32'(key_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(8'b1010_0101, ident);
    check_result(8'b1010_0101, ident, "R3 after reset");

    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end
endmodule